// File: doc/BRIEF.md
# Serial-Configured Clock Output Enable Receiver

This block is a receive-only slave on a two-wire SMBus. It watches the bus clock and data lines, both sampled in the system clock domain, and picks out start, repeated-start and stop conditions. When a write carries its fixed device address, it acknowledges every byte by pulling the data line low through an open-drain enable. It skips the two framing bytes that come after the address and steers the bits of the first data bytes into a set of per-output enable flops.

Each enable flop gates one copy of a reference clock: a set enable lets the copy follow the reference, and a cleared enable holds it low. There is no staging register. Every data bit changes its enable as soon as the bit is complete. A master may therefore end a transfer early with a stop or a repeated start, and every enable it has not reached keeps its value.

Top module: `fanout_cfg_rx`

## Requirements
- R1: After reset, all six enables are 1 (every `clk_out` follows `ref_clk_in`) and `sda_oe_n` is 1, so the data line is released.
- R2: Only the address byte 8'hD2 (7-bit address 7'h69 followed by write bit 0) is accepted. Any other address byte gets no acknowledge, and the enables do not change until the next start.
- R3: Bits arrive MSB first. A bit is the SDA level sampled while SCL is high, and it is taken as complete on the following SCL falling edge.
- R4: An SDA fall while SCL is high is a start. An SDA rise while SCL is high is a stop. Either one discards a bit whose SCL high phase it interrupts. A stop returns the receiver to idle with SDA released.
- R5: After each accepted 8-bit byte, `sda_oe_n` goes to 0 for the ninth SCL pulse and goes back to 1 after that pulse's falling edge.
- R6: The second byte (command) and the third byte (count) are acknowledged, and their values have no effect on any enable.
- R7: The enable mapping is: data byte 0 bit 7 controls output 2, bit 2 controls output 1 and bit 0 controls output 0; data byte 1 bit 7 controls output 5, bit 4 controls output 4 and bit 0 controls output 3. All other bits, and all of data byte 2, have no effect.
- R8: Each data bit updates its enable as soon as that bit completes, before the rest of its byte arrives.
- R9: A stop or a repeated start in the middle of a data byte leaves every enable not yet reached unchanged.
- R10: Data bytes after byte 2, including any beyond the seventh, are acknowledged and ignored.
- R11: `clk_out[i]` is the registered AND of `ref_clk_in` and enable i, and it is low whenever enable i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SMBus clock line level |
| sda_in | input | 1 | SMBus data line level |
| sda_oe_n | output | 1 | Active-low open-drain pull-down enable for SDA |
| ref_clk_in | input | 1 | Reference clock that is fanned out |
| clk_out | output | 6 | Gated copies of the reference |

## Verification
The bench sweeps all 64 combinations of the six enables, with the reserved bits, the framing bytes and data byte 2 filled with varying junk. A wrong bit mapping, or a design that honoured a reserved bit, shows up there as a mismatched output. Address bytes one bit away from the device address, including the read variant, must draw no acknowledge and change nothing, which catches a loose address compare. Transfers cut short mid-byte by a stop or a repeated start check two things: that bits the master never reached stay untouched, and that the SCL pulse inside a stop is not taken as an extra zero bit. A long burst checks that the receiver keeps acknowledging past the last mapped byte and does not wrap back into the mapped bytes.

// File: rtl/fanout_cfg_pkg.sv
package fanout_cfg_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_BITS,
    RX_ACK
  } rx_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } phase_t;

  // Data byte that holds the enable of output o.
  function automatic int ctl_byte(input int o);
    return (o < 3) ? 0 : 1;
  endfunction

  // Bit position inside that byte.
  function automatic int ctl_bit(input int o);
    case (o)
      0: return 0;
      1: return 2;
      2: return 7;
      3: return 0;
      4: return 4;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/fanout_cfg_sync.sv
module fanout_cfg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fanout_cfg_byte_rx.sv
module fanout_cfg_byte_rx
  import fanout_cfg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR  = 8'hD2,
  parameter int         REG_BYTES = 3,
  localparam int        IDX_W     = $clog2(REG_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             sda_oe_n,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [2:0]       wr_bit,
  output logic             wr_val
);
  logic             scl_q, sda_q;
  logic             scl_rise, scl_fall, start_evt, stop_evt, commit;
  rx_state_t        state;
  phase_t           phase;
  logic [2:0]       bit_cnt;
  logic [6:0]       shreg;
  logic             bit_armed, bit_val;
  logic [IDX_W-1:0] data_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_evt = scl_s & scl_q & sda_q & ~sda_s;
    stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    commit    = scl_fall & bit_armed & (state == RX_BITS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      phase     <= PH_ADDR;
      bit_cnt   <= '0;
      shreg     <= '0;
      bit_armed <= 1'b0;
      bit_val   <= 1'b0;
      data_idx  <= '0;
      sda_oe_n  <= 1'b1;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_bit    <= '0;
      wr_val    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state     <= RX_BITS;
        phase     <= PH_ADDR;
        bit_cnt   <= '0;
        bit_armed <= 1'b0;
        data_idx  <= '0;
        sda_oe_n  <= 1'b1;
      end else if (stop_evt) begin
        state     <= RX_IDLE;
        bit_armed <= 1'b0;
        sda_oe_n  <= 1'b1;
      end else begin
        case (state)
          RX_BITS: begin
            if (scl_rise) begin
              bit_armed <= 1'b1;
              bit_val   <= sda_s;
            end
            if (commit) begin
              bit_armed <= 1'b0;
              shreg     <= {shreg[5:0], bit_val};
              bit_cnt   <= bit_cnt + 3'd1;
              if (phase == PH_DATA && data_idx < IDX_W'(REG_BYTES)) begin
                wr_en  <= 1'b1;
                wr_idx <= data_idx;
                wr_bit <= 3'd7 - bit_cnt;
                wr_val <= bit_val;
              end
              if (bit_cnt == 3'd7) begin
                if (phase == PH_ADDR && {shreg, bit_val} != DEV_ADDR) begin
                  state <= RX_IDLE;
                end else begin
                  state    <= RX_ACK;
                  sda_oe_n <= 1'b0;
                end
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_oe_n <= 1'b1;
              state    <= RX_BITS;
              bit_cnt  <= '0;
              case (phase)
                PH_ADDR: phase <= PH_CMD;
                PH_CMD:  phase <= PH_CNT;
                PH_CNT:  phase <= PH_DATA;
                default: if (data_idx < IDX_W'(REG_BYTES)) data_idx <= data_idx + 1'b1;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_stop_releases_R4: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (sda_oe_n && state == RX_IDLE));

  assert_bad_addr_no_ack_R2: assert property (@(posedge clk) disable iff (rst)
    (commit && phase == PH_ADDR && bit_cnt == 3'd7 && {shreg, bit_val} != DEV_ADDR)
      |=> (state == RX_IDLE && sda_oe_n));

  assert_ack_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (state == RX_ACK && scl_fall) |=> sda_oe_n);

  assert_write_only_data_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(phase) == PH_DATA));

endmodule

// File: rtl/fanout_cfg_bank.sv
module fanout_cfg_bank
  import fanout_cfg_pkg::*;
#(
  parameter int  NUM_OUTS  = 6,
  parameter int  REG_BYTES = 3,
  localparam int IDX_W     = $clog2(REG_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [2:0]          wr_bit,
  input  logic                wr_val,
  input  logic                ref_clk_in,
  output logic [NUM_OUTS-1:0] clk_out
);
  logic [NUM_OUTS-1:0] en_q;

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_en
    localparam int B = ctl_byte(i);
    localparam int T = ctl_bit(i);
    always_ff @(posedge clk) begin
      if (rst) en_q[i] <= 1'b1;
      else if (wr_en && wr_idx == IDX_W'(B) && wr_bit == 3'(T)) en_q[i] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_out <= '0;
    else     clk_out <= {NUM_OUTS{ref_clk_in}} & en_q;
  end

  assert_reset_all_on_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&en_q));

  assert_one_bit_per_step_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(en_q ^ $past(en_q)) <= 1);

  assert_disabled_low_R11: assert property (@(posedge clk) disable iff (rst)
    (clk_out & ~$past(en_q)) == '0);

endmodule

// File: rtl/fanout_cfg_rx.sv
module fanout_cfg_rx #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ADDR    = 8'hD2,
  parameter int         REG_BYTES   = 3,
  parameter int         NUM_OUTS    = 6,
  localparam int        IDX_W       = $clog2(REG_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_oe_n,
  input  logic                ref_clk_in,
  output logic [NUM_OUTS-1:0] clk_out
);
  logic             scl_s, sda_s;
  logic             wr_en, wr_val;
  logic [IDX_W-1:0] wr_idx;
  logic [2:0]       wr_bit;

  fanout_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_s));

  fanout_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

  fanout_cfg_byte_rx #(.DEV_ADDR(DEV_ADDR), .REG_BYTES(REG_BYTES)) u_rx (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .sda_oe_n(sda_oe_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(wr_bit), .wr_val(wr_val));

  fanout_cfg_bank #(.NUM_OUTS(NUM_OUTS), .REG_BYTES(REG_BYTES)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(wr_bit),
    .wr_val(wr_val), .ref_clk_in(ref_clk_in), .clk_out(clk_out));

endmodule

// File: tb/fanout_cfg_rx_bench.sv
module fanout_cfg_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       ref_in = 1'b1;
  logic       sda_oe_n;
  logic [5:0] clk_out;
  logic       sda_line;
  logic [5:0] exp_en;
  logic [7:0] dq [0:15];
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  assign sda_line = m_sda & sda_oe_n;

  always #2.5 clk = ~clk;

  fanout_cfg_rx u_fanout_cfg_rx (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .sda_oe_n(sda_oe_n), .ref_clk_in(ref_in), .clk_out(clk_out));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench model of the enable mapping (R7).
  task automatic mbit(input int idx, input int pos, input logic v);
    if (idx == 0) begin
      if (pos == 7) exp_en[2] = v;
      if (pos == 2) exp_en[1] = v;
      if (pos == 0) exp_en[0] = v;
    end else if (idx == 1) begin
      if (pos == 7) exp_en[5] = v;
      if (pos == 4) exp_en[4] = v;
      if (pos == 0) exp_en[3] = v;
    end
  endtask

  task automatic sbit(input logic b);
    tick(3); m_sda = b; tick(3); scl = 1'b1; tick(6); scl = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sbit(v[i]);
    tick(3); m_sda = 1'b1; tick(3); scl = 1'b1; tick(3);
    ack = ~sda_line;
    tick(3); scl = 1'b0;
  endtask

  task automatic start_c;
    m_sda = 1'b1; scl = 1'b1; tick(6); m_sda = 1'b0; tick(6); scl = 1'b0;
  endtask

  task automatic rstart_c;
    tick(3); m_sda = 1'b1; tick(3); scl = 1'b1; tick(6); m_sda = 1'b0; tick(6); scl = 1'b0;
  endtask

  task automatic stop_c;
    tick(3); m_sda = 1'b0; tick(3); scl = 1'b1; tick(6); m_sda = 1'b1; tick(6);
  endtask

  // Full write: address, command, count, then n data bytes from dq.
  task automatic write_txn(input logic [7:0] addr, input logic [7:0] cmd,
                           input logic [7:0] cnt, input int n, output int acks);
    logic a;
    acks = 0;
    start_c;
    sbyte(addr, a); acks += a;
    sbyte(cmd, a);  acks += a;
    sbyte(cnt, a);  acks += a;
    for (int k = 0; k < n; k++) begin
      sbyte(dq[k], a); acks += a;
      if (addr == 8'hD2)
        for (int b = 7; b >= 0; b--) mbit(k, b, dq[k][b]);
    end
    stop_c;
  endtask

  task automatic chk_outs(input string req);
    ref_in = 1'b1; tick(4);
    chk(req, 32'(clk_out), 32'(exp_en));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int acks;
    logic a;
    logic [7:0] bad_addr [0:3];
    bad_addr[0] = 8'hD0; bad_addr[1] = 8'hD3; bad_addr[2] = 8'h52; bad_addr[3] = 8'hD6;
    exp_en = 6'h3F;
    tick(4); rst = 1'b0; tick(4);
    chk("R1 reset enables", 32'(clk_out), 32'h3F);
    chk("R1 reset sda released", 32'(sda_oe_n), 32'h1);

    // R7 R6 R3: sweep all 64 enable patterns, reserved bits and framing junk.
    for (int p = 0; p < 64; p++) begin
      logic [7:0] r0, r1;
      r0 = (p % 3 == 0) ? 8'h7A : 8'h00;
      r1 = (p % 3 == 1) ? 8'h6E : 8'h00;
      dq[0] = r0 | {p[2], 4'b0, p[1], 1'b0, p[0]};
      dq[1] = r1 | {p[5], 2'b0, p[4], 3'b0, p[3]};
      dq[2] = 8'(p * 37 + 5);
      write_txn(8'hD2, 8'(p), 8'(~p), 3, acks);
      chk("R5 acks per byte", 32'(acks), 32'd6);
      tick(6);
      chk_outs("R7 R6 mapping sweep");
    end

    // R2: addresses other than D2 get no ack and change nothing.
    dq[0] = 8'h00; dq[1] = 8'h00; dq[2] = 8'h00;
    write_txn(8'hD2, 8'h00, 8'h00, 2, acks);
    dq[0] = 8'hFF; dq[1] = 8'hFF;
    tick(6); chk_outs("R2 baseline");
    for (int k = 0; k < 4; k++) begin
      write_txn(bad_addr[k], 8'h00, 8'h00, 2, acks);
      chk("R2 no ack on wrong address", 32'(acks), 32'd0);
      tick(6);
      chk_outs("R2 wrong address ignored");
    end

    // R8 R9: stop after three bits of data byte 0.
    dq[0] = 8'hFF; dq[1] = 8'hFF;
    write_txn(8'hD2, 8'h11, 8'h22, 2, acks);
    tick(6); chk_outs("R9 preset");
    start_c;
    sbyte(8'hD2, a); sbyte(8'h00, a); sbyte(8'h00, a);
    sbit(1'b0); tick(8);
    exp_en[2] = 1'b0;
    chk("R8 bit takes effect mid-byte", 32'(clk_out), 32'(exp_en));
    sbit(1'b0); sbit(1'b0);
    stop_c; tick(6);
    chk_outs("R9 stop truncation");

    // R9 R4: repeated start in data byte 1 after four zero bits.
    start_c;
    sbyte(8'hD2, a); sbyte(8'h00, a); sbyte(8'h00, a);
    sbyte(8'h00, a);
    for (int b = 7; b >= 0; b--) mbit(0, b, 1'b0);
    for (int b = 0; b < 4; b++) sbit(1'b0);
    exp_en[5] = 1'b0; exp_en[4] = 1'b0;
    rstart_c;
    sbyte(8'hD2, a);
    chk("R4 ack after repeated start", 32'(a), 32'h1);
    sbyte(8'h00, a); sbyte(8'h00, a);
    stop_c; tick(6);
    chk_outs("R9 repeated start truncation");
    chk("R9 expected pattern", 32'(exp_en), 32'h08);
    chk("R4 released after stop", 32'(sda_oe_n), 32'h1);

    // R10: long burst of 12 data bytes, all acked, extra bytes ignored.
    dq[0] = 8'h85; dq[1] = 8'h00; dq[2] = 8'hFF;
    for (int k = 3; k < 12; k++) dq[k] = 8'h00;
    write_txn(8'hD2, 8'hAA, 8'h55, 12, acks);
    chk("R10 acks on long burst", 32'(acks), 32'd15);
    tick(6); chk_outs("R10 extra bytes ignored");
    chk("R10 expected pattern", 32'(exp_en), 32'h07);

    // R11: gating follows the reference.
    ref_in = 1'b0; tick(4);
    chk("R11 reference low", 32'(clk_out), 32'h00);
    ref_in = 1'b1; tick(4);
    chk("R11 reference high", 32'(clk_out), 32'(exp_en));

    // R1: reset restores all enables.
    rst = 1'b1; tick(3); rst = 1'b0; tick(4);
    exp_en = 6'h3F;
    chk("R1 reset after writes", 32'(clk_out), 32'h3F);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule